// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Register

This block is the serial test port of one device. A controller with sixteen states moves on each rising edge of `tck` as `tms` directs. It has one branch of states for the instruction register and a parallel branch for the data registers. The instruction register is a shift stage and a hold stage. It is decoded into a choice of one data register to sit between `tdi` and `tdo`: a one-bit bypass stage, a 32-bit identification word, or an external boundary chain.

The boundary cells are outside the block. The block gives them a shift control, a capture/shift clock enable, an update strobe, a mode bit and a chain-select. The chain's serial output returns on `bsrSerialIn`. All sequencing in the block is synchronous to `tck`, except `trstN`, which acts at once. `tdo` changes only on falling edges of `tck`.

Top module: `tapPort`

## Requirements
- R1: On each rising `tck` edge the controller takes the standard next state for the current state and `tms`. This includes the pause and exit loops of both branches.
- R2: While `trstN` is low, the controller is held in the test-logic-reset state and the instruction is set to `OP_IDCODE` at once. `tdo` is 0 and every boundary control output is low.
- R3: Five rising `tck` edges with `tms` high reach the test-logic-reset state from any state. A rising edge in that state loads `OP_IDCODE` into the instruction.
- R4: On capture of the instruction register, the shift stage loads the value with bit 0 = 1, bit 1 = 0 and every higher bit 0. It shifts LSB first: `tdi` enters the MSB and bit 0 goes out on `tdo`.
- R5: The active instruction changes only on the rising edge that leaves the update-instruction state, or in test-logic-reset. It does not change while a new instruction is being shifted in.
- R6: The all-zeros instruction selects the one-bit bypass stage. That stage captures 0, and a bit on `tdi` appears on `tdo` after one shift edge.
- R7: Instruction `OP_IDCODE` selects the 32-bit identification register. On capture it loads `ID_VALUE` with bit 0 forced to 1, and it shifts out LSB first.
- R8: The all-ones instruction (external test) and `OP_SAMPLE` select the boundary chain with `bsrMode` = 0. `OP_INTEST` and `OP_RUNBIST` select the chain with `bsrMode` = 1. When the chain is selected, its serial input drives `tdo` during the data shift.
- R9: Any instruction code that is not assigned acts as bypass. The chain is not selected and `bsrMode` = 0.
- R10: `tdo` is updated on the falling `tck` edge. It carries register data only in the two shift states and is 0 in every other state.
- R11: `bsrShift` is high in the shift-data state. `bsrClock` is high in the capture-data and shift-data states, and `bsrUpdate` is high in the update-data state. Both `bsrClock` and `bsrUpdate` are high only while the chain is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select steering the controller |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| bsrSerialIn | input | 1 | Serial output of the external boundary chain |
| bsrSelect | output | 1 | Boundary chain is the active data register |
| bsrMode | output | 1 | Boundary cell mode: 1 for internal test/self-test, 0 otherwise |
| bsrShift | output | 1 | Boundary cells select serial path |
| bsrClock | output | 1 | Boundary capture/shift enable |
| bsrUpdate | output | 1 | Boundary update strobe |

## Verification
A wrong controller state shows on the boundary strobes within the same half period, because `bsrShift`, `bsrClock` and `bsrUpdate` follow the state directly. It also shows on `tdo` at the next falling edge, where a shift state is missed or appears where none should. A corrupted instruction changes `bsrSelect` and `bsrMode` at once. It then changes the bits shifted out in the next data scan, because bypass, identification and chain data differ. A bad capture value or shift direction in any register shows within the first bits of the scan that follows.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET    = 4'd0,
    ST_IDLE     = 4'd1,
    ST_SEL_DR   = 4'd2,
    ST_CAP_DR   = 4'd3,
    ST_SH_DR    = 4'd4,
    ST_EX1_DR   = 4'd5,
    ST_PAUSE_DR = 4'd6,
    ST_EX2_DR   = 4'd7,
    ST_UPD_DR   = 4'd8,
    ST_SEL_IR   = 4'd9,
    ST_CAP_IR   = 4'd10,
    ST_SH_IR    = 4'd11,
    ST_EX1_IR   = 4'd12,
    ST_PAUSE_IR = 4'd13,
    ST_EX2_IR   = 4'd14,
    ST_UPD_IR   = 4'd15
  } tapState_e;

  // strobes handed from the controller to the register datapath
  typedef struct packed {
    logic resetIr;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapStrobe_t;

  typedef enum logic [1:0] {
    DR_BYPASS = 2'd0,
    DR_IDENT  = 2'd1,
    DR_CHAIN  = 2'd2
  } drSel_e;

endpackage

// File: rtl/tapCtrl.sv
module tapCtrl
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  output tapStrobe_t strb
);

  tapState_e curState;
  tapState_e nxtState;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) curState <= ST_RESET;
    else        curState <= nxtState;
  end

  always_comb begin
    nxtState = curState;
    unique case (curState)
      ST_RESET:    nxtState = tms ? ST_RESET   : ST_IDLE;
      ST_IDLE:     nxtState = tms ? ST_SEL_DR  : ST_IDLE;
      ST_SEL_DR:   nxtState = tms ? ST_SEL_IR  : ST_CAP_DR;
      ST_CAP_DR:   nxtState = tms ? ST_EX1_DR  : ST_SH_DR;
      ST_SH_DR:    nxtState = tms ? ST_EX1_DR  : ST_SH_DR;
      ST_EX1_DR:   nxtState = tms ? ST_UPD_DR  : ST_PAUSE_DR;
      ST_PAUSE_DR: nxtState = tms ? ST_EX2_DR  : ST_PAUSE_DR;
      ST_EX2_DR:   nxtState = tms ? ST_UPD_DR  : ST_SH_DR;
      ST_UPD_DR:   nxtState = tms ? ST_SEL_DR  : ST_IDLE;
      ST_SEL_IR:   nxtState = tms ? ST_RESET   : ST_CAP_IR;
      ST_CAP_IR:   nxtState = tms ? ST_EX1_IR  : ST_SH_IR;
      ST_SH_IR:    nxtState = tms ? ST_EX1_IR  : ST_SH_IR;
      ST_EX1_IR:   nxtState = tms ? ST_UPD_IR  : ST_PAUSE_IR;
      ST_PAUSE_IR: nxtState = tms ? ST_EX2_IR  : ST_PAUSE_IR;
      ST_EX2_IR:   nxtState = tms ? ST_UPD_IR  : ST_SH_IR;
      ST_UPD_IR:   nxtState = tms ? ST_SEL_DR  : ST_IDLE;
      default:     nxtState = ST_RESET;
    endcase
  end

  always_comb begin
    strb.resetIr   = (curState == ST_RESET);
    strb.captureIr = (curState == ST_CAP_IR);
    strb.shiftIr   = (curState == ST_SH_IR);
    strb.updateIr  = (curState == ST_UPD_IR);
    strb.captureDr = (curState == ST_CAP_DR);
    strb.shiftDr   = (curState == ST_SH_DR);
    strb.updateDr  = (curState == ST_UPD_DR);
  end

endmodule

// File: rtl/tapData.sv
module tapData
  import tap_pkg::*;
#(
  parameter int              IR_W       = 4,
  parameter int              ID_W       = 32,
  parameter logic [ID_W-1:0] ID_VALUE   = 32'h5C3A_91E7,
  parameter logic [IR_W-1:0] OP_IDCODE  = 4'b0001,
  parameter logic [IR_W-1:0] OP_SAMPLE  = 4'b0010,
  parameter logic [IR_W-1:0] OP_INTEST  = 4'b0100,
  parameter logic [IR_W-1:0] OP_RUNBIST = 4'b1000
)(
  input  logic            tck,
  input  logic            trstN,
  input  logic            tdi,
  input  tapStrobe_t      strb,
  input  logic            bsrSerialIn,
  output logic            tdo,
  output logic            bsrSelect,
  output logic            bsrMode,
  output logic            bsrShift,
  output logic            bsrClock,
  output logic            bsrUpdate,
  output logic [IR_W-1:0] instr
);

  localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);
  localparam logic [IR_W-1:0] OP_EXTEST  = '1;
  localparam logic [ID_W-1:0] ID_CAPTURE = {ID_VALUE[ID_W-1:1], 1'b1};
  localparam logic            TDO_IDLE   = 1'b0;

  logic [IR_W-1:0] irShift;
  logic [ID_W-1:0] idShift;
  logic            bypassBit;
  drSel_e          drSel;
  logic            modeSel;
  logic            serialOut;

  // instruction shift stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              irShift <= IR_CAPTURE;
    else if (strb.captureIr) irShift <= IR_CAPTURE;
    else if (strb.shiftIr)   irShift <= {tdi, irShift[IR_W-1:1]};
  end

  // instruction hold stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)             instr <= OP_IDCODE;
    else if (strb.resetIr)  instr <= OP_IDCODE;
    else if (strb.updateIr) instr <= irShift;
  end

  // one-bit bypass stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              bypassBit <= 1'b0;
    else if (strb.captureDr) bypassBit <= 1'b0;
    else if (strb.shiftDr)   bypassBit <= tdi;
  end

  // identification register
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              idShift <= ID_CAPTURE;
    else if (strb.captureDr) idShift <= ID_CAPTURE;
    else if (strb.shiftDr)   idShift <= {tdi, idShift[ID_W-1:1]};
  end

  // instruction decode
  always_comb begin
    drSel   = DR_BYPASS;
    modeSel = 1'b0;
    case (instr)
      OP_EXTEST:  drSel = DR_CHAIN;
      OP_SAMPLE:  drSel = DR_CHAIN;
      OP_IDCODE:  drSel = DR_IDENT;
      OP_INTEST:  begin drSel = DR_CHAIN; modeSel = 1'b1; end
      OP_RUNBIST: begin drSel = DR_CHAIN; modeSel = 1'b1; end
      default:    drSel = DR_BYPASS;
    endcase
  end

  always_comb begin
    unique case (drSel)
      DR_IDENT: serialOut = idShift[0];
      DR_CHAIN: serialOut = bsrSerialIn;
      default:  serialOut = bypassBit;
    endcase
  end

  // falling-edge output stage
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)            tdo <= TDO_IDLE;
    else if (strb.shiftIr) tdo <= irShift[0];
    else if (strb.shiftDr) tdo <= serialOut;
    else                   tdo <= TDO_IDLE;
  end

  assign bsrSelect = (drSel == DR_CHAIN);
  assign bsrMode   = modeSel;
  assign bsrShift  = strb.shiftDr;
  assign bsrClock  = bsrSelect & (strb.captureDr | strb.shiftDr);
  assign bsrUpdate = bsrSelect & strb.updateDr;

endmodule

// File: rtl/tapPort.sv
module tapPort
  import tap_pkg::*;
#(
  parameter int              IR_W       = 4,
  parameter int              ID_W       = 32,
  parameter logic [ID_W-1:0] ID_VALUE   = 32'h5C3A_91E7,
  parameter logic [IR_W-1:0] OP_IDCODE  = 4'b0001,
  parameter logic [IR_W-1:0] OP_SAMPLE  = 4'b0010,
  parameter logic [IR_W-1:0] OP_INTEST  = 4'b0100,
  parameter logic [IR_W-1:0] OP_RUNBIST = 4'b1000
)(
  input  logic tck,
  input  logic trstN,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  input  logic bsrSerialIn,
  output logic bsrSelect,
  output logic bsrMode,
  output logic bsrShift,
  output logic bsrClock,
  output logic bsrUpdate
);

  tapStrobe_t      strb;
  logic [IR_W-1:0] instr;

  tapCtrl u_ctrl (
    .tck   (tck),
    .trstN (trstN),
    .tms   (tms),
    .strb  (strb)
  );

  tapData #(
    .IR_W       (IR_W),
    .ID_W       (ID_W),
    .ID_VALUE   (ID_VALUE),
    .OP_IDCODE  (OP_IDCODE),
    .OP_SAMPLE  (OP_SAMPLE),
    .OP_INTEST  (OP_INTEST),
    .OP_RUNBIST (OP_RUNBIST)
  ) u_data (
    .tck         (tck),
    .trstN       (trstN),
    .tdi         (tdi),
    .strb        (strb),
    .bsrSerialIn (bsrSerialIn),
    .tdo         (tdo),
    .bsrSelect   (bsrSelect),
    .bsrMode     (bsrMode),
    .bsrShift    (bsrShift),
    .bsrClock    (bsrClock),
    .bsrUpdate   (bsrUpdate),
    .instr       (instr)
  );

endmodule

// File: rtl/tapPort_checker.sv
module tapPort_checker
  import tap_pkg::*;
#(
  parameter int              IR_W      = 4,
  parameter logic [IR_W-1:0] OP_IDCODE = 4'b0001
)(
  input logic            tck,
  input logic            trstN,
  input logic            tms,
  input logic            tdo,
  input logic            bsrSelect,
  input logic            bsrMode,
  input logic            bsrClock,
  input tapStrobe_t      strb,
  input logic [IR_W-1:0] instr
);

  // R3: five high tms edges leave the controller in test-logic-reset
  a_r3_five_tms_high: assert property (@(posedge tck) disable iff (!trstN)
    ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
      |-> strb.resetIr);

  // R2 / R3: an edge in test-logic-reset leaves IDCODE active
  a_r2_reset_loads_idcode: assert property (@(posedge tck) disable iff (!trstN)
    strb.resetIr |=> (instr == OP_IDCODE));

  // R5: instruction holds outside update-IR and reset
  a_r5_ir_hold: assert property (@(posedge tck) disable iff (!trstN)
    (!strb.updateIr && !strb.resetIr) |=> $stable(instr));

  // R10: tdo idles at 0 outside the shift states
  a_r10_tdo_idle: assert property (@(posedge tck) disable iff (!trstN)
    (!strb.shiftIr && !strb.shiftDr) |-> (tdo == 1'b0));

  // R11: chain clock enable only in capture-DR or shift-DR
  a_r11_clock_in_dr: assert property (@(posedge tck) disable iff (!trstN)
    bsrClock |-> (strb.captureDr || strb.shiftDr));

  // R8: mode 1 only with the chain selected
  a_r8_mode_needs_chain: assert property (@(posedge tck) disable iff (!trstN)
    bsrMode |-> bsrSelect);

endmodule

bind tapPort tapPort_checker #(
  .IR_W      (IR_W),
  .OP_IDCODE (OP_IDCODE)
) u_chk (
  .tck       (tck),
  .trstN     (trstN),
  .tms       (tms),
  .tdo       (tdo),
  .bsrSelect (bsrSelect),
  .bsrMode   (bsrMode),
  .bsrClock  (bsrClock),
  .strb      (strb),
  .instr     (instr)
);

// File: tb/tapPort_bench.sv
module tapPort_bench;

  localparam int          PERIOD  = 10;
  localparam int          IRW     = 4;
  localparam logic [31:0] IDV     = 32'h5C3A_91E7;
  localparam logic [3:0]  C_IDC   = 4'b0001;
  localparam logic [3:0]  C_SAMP  = 4'b0010;
  localparam logic [3:0]  C_INT   = 4'b0100;
  localparam logic [3:0]  C_BIST  = 4'b1000;
  localparam logic [3:0]  C_EXT   = 4'b1111;
  localparam logic [3:0]  C_BYP   = 4'b0000;

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic bsrSerialIn = 1'b0;
  logic tdo, bsrSelect, bsrMode, bsrShift, bsrClock, bsrUpdate;

  int vectors = 0;
  int misses = 0;

  // reference model state
  int         mState;
  logic [3:0] mIr, mIrSh;
  logic       mByp, mTdo;
  logic [31:0] mId;

  tapPort u_tapPort (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo),
    .bsrSerialIn(bsrSerialIn), .bsrSelect(bsrSelect), .bsrMode(bsrMode),
    .bsrShift(bsrShift), .bsrClock(bsrClock), .bsrUpdate(bsrUpdate)
  );

  always #(PERIOD/2) tck = ~tck;

  function automatic int nextOf(int s, logic m);
    case (s)
      0: return m ? 0 : 1;    1: return m ? 2 : 1;
      2: return m ? 9 : 3;    3: return m ? 5 : 4;
      4: return m ? 5 : 4;    5: return m ? 8 : 6;
      6: return m ? 7 : 6;    7: return m ? 8 : 4;
      8: return m ? 2 : 1;    9: return m ? 0 : 10;
      10: return m ? 12 : 11; 11: return m ? 12 : 11;
      12: return m ? 15 : 13; 13: return m ? 14 : 13;
      14: return m ? 15 : 11; default: return m ? 2 : 1;
    endcase
  endfunction

  function automatic logic chainSel(logic [3:0] op);
    return op == C_EXT || op == C_SAMP || op == C_INT || op == C_BIST;
  endfunction

  function automatic logic modeOf(logic [3:0] op);
    return op == C_INT || op == C_BIST;
  endfunction

  task automatic modelReset();
    mState = 0; mIr = C_IDC; mIrSh = 4'b0001; mByp = 1'b0; mId = IDV; mTdo = 1'b0;
  endtask

  task automatic cmp1(string tag, string name, logic act, logic exp);
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%b expected=%b state=%0d t=%0t", tag, name, act, exp, mState, $time);
    end
  endtask

  task automatic compareAll(string tag);
    logic sel;
    sel = chainSel(mIr);
    vectors++;
    cmp1(tag, "tdo", tdo, mTdo);
    cmp1(tag, "bsrSelect", bsrSelect, sel);
    cmp1(tag, "bsrMode", bsrMode, modeOf(mIr));
    cmp1(tag, "bsrShift", bsrShift, mState == 4);
    cmp1(tag, "bsrClock", bsrClock, sel && (mState == 3 || mState == 4));
    cmp1(tag, "bsrUpdate", bsrUpdate, sel && mState == 8);
  endtask

  // one tck cycle: drive while low, model both edges, compare after falling edge
  task automatic step(logic m, logic d, string tag);
    tms = m; tdi = d; bsrSerialIn = 1'($urandom);
    @(posedge tck);
    case (mState)
      0:  mIr = C_IDC;
      10: mIrSh = 4'b0001;
      11: mIrSh = {d, mIrSh[3:1]};
      15: mIr = mIrSh;
      3:  begin mByp = 1'b0; mId = IDV; end
      4:  begin mByp = d; mId = {d, mId[31:1]}; end
      default: ;
    endcase
    mState = nextOf(mState, m);
    @(negedge tck);
    if (mState == 11) mTdo = mIrSh[0];
    else if (mState == 4) begin
      if (chainSel(mIr))   mTdo = bsrSerialIn;
      else if (mIr == C_IDC) mTdo = mId[0];
      else                 mTdo = mByp;
    end else mTdo = 1'b0;
    #1;
    compareAll(tag);
  endtask

  // from idle: load an instruction and return to idle
  task automatic loadIr(logic [3:0] op, string tag);
    step(1, 0, tag); step(1, 0, tag); step(0, 0, tag); step(0, 0, tag);
    for (int i = 0; i < IRW; i++) step(i == IRW-1, op[i], tag);
    step(1, 0, tag); step(0, 0, tag);
  endtask

  // from idle: scan n data bits and return to idle
  task automatic scanDr(int n, string tag);
    step(1, 0, tag); step(0, 0, tag); step(0, 0, tag);
    for (int i = 0; i < n; i++) step(i == n-1, 1'($urandom), tag);
    step(1, 0, tag); step(0, 0, tag);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(PERIOD*150000);
    misses++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    modelReset();
    #(PERIOD*2 + 2);
    compareAll("R2");                       // reset state at the ports
    @(negedge tck); #1;
    trstN = 1'b1;
    step(1, 0, "R2"); step(1, 0, "R2"); step(0, 0, "R2");
    scanDr(40, "R7");                       // identification word after reset
    loadIr(C_SAMP, "R4");                   // shifted-out capture shows ...01
    scanDr(12, "R8"); scanDr(5, "R11");
    loadIr(C_INT, "R8");  scanDr(6, "R8");
    loadIr(C_BIST, "R8"); scanDr(6, "R11");
    loadIr(C_EXT, "R5");  scanDr(6, "R8");
    loadIr(C_BYP, "R6");  scanDr(20, "R6");
    loadIr(4'b0011, "R9"); scanDr(10, "R9");
    loadIr(4'b1010, "R9"); scanDr(10, "R9");
    // pause and exit loops on both branches
    step(1, 0, "R1"); step(0, 0, "R1"); step(0, 1, "R1"); step(1, 1, "R10");
    step(0, 0, "R10"); step(0, 0, "R10"); step(1, 0, "R1"); step(0, 1, "R1");
    step(0, 0, "R1"); step(1, 1, "R1"); step(1, 0, "R1"); step(0, 0, "R1");
    step(1, 0, "R1"); step(1, 0, "R1"); step(0, 0, "R1"); step(0, 1, "R1");
    step(1, 0, "R1"); step(0, 0, "R10"); step(1, 0, "R1"); step(0, 1, "R1");
    step(1, 1, "R1"); step(1, 0, "R5"); step(0, 0, "R1");
    scanDr(8, "R10");
    // five high tms from assorted states
    for (int k = 0; k < 16; k++) begin
      loadIr(C_EXT, "R3");
      for (int j = 0; j < k; j++) step(1'($urandom), 1'($urandom), "R3");
      for (int j = 0; j < 5; j++) step(1, 0, "R3");
      step(0, 0, "R3");
      scanDr(8, "R3");
    end
    // random walk
    for (int i = 0; i < 600; i++) step(1'($urandom), 1'($urandom), "R1");
    // asynchronous reset in mid-run
    loadIr(C_INT, "R2");
    step(1, 0, "R2"); step(0, 0, "R2");
    trstN = 1'b0; #2; modelReset(); compareAll("R2");
    @(negedge tck); #1; compareAll("R2");
    trstN = 1'b1;
    step(0, 0, "R2"); scanDr(34, "R7");
    finishRun();
  end

endmodule